// File: doc/BRIEF.md
# S/PDIF Biphase Subframe Transmitter

This block turns a stream of 24-bit audio samples into a single serial line for a consumer digital audio link. A frame holds two 32-slot subframes, channel A and then channel B, and every slot takes two line cells. The block is clocked at 128 times the sample rate and puts out one line cell per clock. Each subframe starts with a four-slot synchronisation preamble that deliberately breaks the line code. Next come 24 audio slots, then the validity, user and channel-status flags, and last a parity slot. All slots after the preamble use biphase-mark coding.

Samples come from an upstream unpacker through a valid/ready handshake into a one-entry holding slot, which is emptied at each subframe boundary. Channel-status bits are taken from two 192-bit banks, one for each channel, and are indexed by the frame number within a 192-frame block. The validity, user and channel-status flags can each be driven from a manual value or from the data path. A select value of 0 picks the manual value. Setting the manual validity bit is the digital mute. Two active-low soft resets, one for the output side and one for the input side, must both be released before the enable has any effect. Software releases the output side first.

Top module: `spdif_tx`

## Requirements
- R1: Out of rst_n the line is 0 and stays 0 until tx_en=1 with both oside_rst_n=1 and iside_rst_n=1. Holding either soft reset low keeps the line at 0 whatever tx_en is.
- R2: If tx_en is 0 at a clock edge, the line is 0 after that edge. When tx_en is set again, transmission restarts at frame 0, channel A, from line level 0.
- R3: The first line cell appears two edges after the edge that samples tx_en=1. Each frame is 128 cells: 64 cells of channel A, then 64 cells of channel B.
- R4: Cells 0..7 of a subframe are a preamble pattern, first cell first. The pattern is 11101000 on channel A of frame 0 of each 192-frame block, 11100010 on the other channel-A subframes, and 11100100 on channel B. A pattern 1 is the inverse of the line level just before the subframe.
- R5: Slots 4..31 (cells 8..63) use biphase-mark coding. The line toggles at the start of each slot, and toggles again at mid-slot when the slot bit is 1.
- R6: With msb_first=0, sample bit i goes in slot 4+i, so the MSB lands in slot 27. With msb_first=1, sample bit 23-i goes in slot 4+i.
- R7: Slot 31 holds parity, chosen so that slots 4..31 together carry an even number of ones.
- R8: Slot 28 is validity. With v_dp_sel=0 it is v_man, where 1 means invalid and acts as mute. With v_dp_sel=1 it is 1 when no sample was waiting at the subframe boundary (audio is then 0), and 0 otherwise.
- R9: Slot 29 is the user bit. It is u_man when u_dp_sel=0, and the sample's smp_user when u_dp_sel=1 (0 on underrun).
- R10: Slot 30 is channel status. With c_dp_sel=0 it is bit n of cs_a (channel A) or cs_b (channel B) in frame n, and the frame count wraps from 191 to 0. With c_dp_sel=1 it is the sample's smp_cs (0 on underrun).
- R11: smp_ready is high only while iside_rst_n=1 and the one-entry slot is empty. Pulling iside_rst_n low discards a held sample. In stereo, consecutive samples go to A0, B0, A1, B1 and so on.
- R12: With mono=1, channel B repeats the audio, user, status and validity used for channel A of the same frame, and takes nothing from the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, 128 x sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| oside_rst_n | input | 1 | Output-side soft reset, active low |
| iside_rst_n | input | 1 | Input-side soft reset, active low |
| mono | input | 1 | Channel B repeats channel A |
| msb_first | input | 1 | Audio slot order select |
| v_dp_sel | input | 1 | Validity from data path when 1 |
| v_man | input | 1 | Manual validity value (1 = mute) |
| u_dp_sel | input | 1 | User bit from data path when 1 |
| u_man | input | 1 | Manual user bit |
| c_dp_sel | input | 1 | Channel status from data path when 1 |
| cs_a | input | 192 | Channel A status bank, bit n for frame n |
| cs_b | input | 192 | Channel B status bank, bit n for frame n |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Holding slot can take a sample |
| smp_data | input | 24 | Audio sample |
| smp_user | input | 1 | Sample's user bit |
| smp_cs | input | 1 | Sample's channel-status bit |
| tx_line | output | 1 | Serial biphase line |

## Verification
The assertions assume that the soft resets and the mode inputs change only while tx_en is low. They also assume that a sample, once offered, stays stable until it is accepted, so the one-deep slot never sees a value withdrawn. The bench changes every mode bit only between runs, after a full reset sequence in which the output side is released first. Its feeder holds smp_valid and smp_data steady from one falling edge to the next and advances only after an accepting edge. Underrun is produced only by running out of queued samples, never by pulling a sample back.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int AUD_W = 24;
  localparam int SLOT_AUD0 = 4;

  typedef enum logic [1:0] {PRE_BLK, PRE_A, PRE_B} pre_e;

  function automatic logic [7:0] pre_pattern(input pre_e kind);
    case (kind)
      PRE_BLK: pre_pattern = 8'b1110_1000;
      PRE_A:   pre_pattern = 8'b1110_0010;
      default: pre_pattern = 8'b1110_0100;
    endcase
  endfunction

  // slot-indexed subframe word; slots 0..3 are the preamble and stay 0
  function automatic logic [31:0] build_word(input logic [AUD_W-1:0] aud,
                                             input logic msb, input logic v,
                                             input logic u, input logic c);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < AUD_W; i++)
      w[SLOT_AUD0+i] = msb ? aud[AUD_W-1-i] : aud[i];
    w[28] = v;
    w[29] = u;
    w[30] = c;
    w[31] = ^w[30:4];
    return w;
  endfunction
endpackage

// File: rtl/spdif_cell_timer.sv
module spdif_cell_timer #(
  parameter int BLOCK = 192
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  output logic                     active,
  output logic [6:0]               pos,
  output logic [$clog2(BLOCK)-1:0] frame,
  output logic                     ld,
  output logic                     ld_chb,
  output logic [$clog2(BLOCK)-1:0] ld_frame
);
  localparam int FW = $clog2(BLOCK);
  localparam logic [FW-1:0] LAST = FW'(BLOCK - 1);

  logic [FW-1:0] nxt_frame;

  assign nxt_frame = (frame == LAST) ? '0 : frame + 1'b1;
  assign ld        = run && (!active || pos[5:0] == 6'h3F);
  assign ld_chb    = active && !pos[6];
  assign ld_frame  = !active ? '0 : (pos[6] ? nxt_frame : frame);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      frame  <= '0;
    end else if (!run) begin
      active <= 1'b0;
      pos    <= '0;
      frame  <= '0;
    end else if (!active) begin
      active <= 1'b1;
      pos    <= '0;
      frame  <= '0;
    end else begin
      pos <= pos + 7'd1;
      if (pos == 7'h7F) frame <= nxt_frame;
    end
  end
endmodule

// File: rtl/spdif_sample_slot.sv
module spdif_sample_slot #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iside_rst_n,
  input  logic          smp_valid,
  input  logic [AW-1:0] smp_data,
  input  logic          smp_user,
  input  logic          smp_cs,
  input  logic          consume,
  output logic          smp_ready,
  output logic          hv,
  output logic [AW-1:0] hd,
  output logic          hu,
  output logic          hc
);
  assign smp_ready = iside_rst_n && !hv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv <= 1'b0;
      hd <= '0;
      hu <= 1'b0;
      hc <= 1'b0;
    end else if (!iside_rst_n) begin
      hv <= 1'b0;
    end else if (smp_valid && smp_ready) begin
      hv <= 1'b1;
      hd <= smp_data;
      hu <= smp_user;
      hc <= smp_cs;
    end else if (consume) begin
      hv <= 1'b0;
    end
  end
endmodule

// File: rtl/spdif_bmc_coder.sv
module spdif_bmc_coder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        active,
  input  logic [6:0]  pos,
  input  logic [31:0] word,
  input  logic [7:0]  pat,
  output logic        line
);
  logic pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line <= 1'b0;
      pol  <= 1'b0;
    end else if (!run) begin
      line <= 1'b0;
      pol  <= 1'b0;
    end else if (active) begin
      if (pos[5:3] == 3'd0) begin
        if (pos[2:0] == 3'd0) begin
          pol  <= line;
          line <= pat[7] ^ line;
        end else begin
          line <= pat[3'd7 - pos[2:0]] ^ pol;
        end
      end else if (!pos[0]) begin
        line <= ~line;
      end else begin
        line <= line ^ word[pos[5:1]];
      end
    end
  end
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx #(
  parameter int BLOCK = 192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_en,
  input  logic                    oside_rst_n,
  input  logic                    iside_rst_n,
  input  logic                    mono,
  input  logic                    msb_first,
  input  logic                    v_dp_sel,
  input  logic                    v_man,
  input  logic                    u_dp_sel,
  input  logic                    u_man,
  input  logic                    c_dp_sel,
  input  logic [BLOCK-1:0]        cs_a,
  input  logic [BLOCK-1:0]        cs_b,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [spdif_tx_pkg::AUD_W-1:0] smp_data,
  input  logic                    smp_user,
  input  logic                    smp_cs,
  output logic                    tx_line
);
  import spdif_tx_pkg::*;
  localparam int FW = $clog2(BLOCK);

  logic             run, active, ld, ld_chb, consume;
  logic [6:0]       pos;
  logic [FW-1:0]    frame, ld_frame;
  logic             hv, hu, hc;
  logic [AUD_W-1:0] hd;
  logic [31:0]      word_q;
  logic [7:0]       pat_q;
  logic [AUD_W-1:0] a_d;
  logic             a_u, a_c, a_v;
  logic             take, reuse, dp_v, cur_u, cur_c, bank_bit;
  logic [AUD_W-1:0] cur_d;
  pre_e             kind;

  assign run = tx_en && oside_rst_n && iside_rst_n;

  spdif_cell_timer #(.BLOCK(BLOCK)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .active(active), .pos(pos),
    .frame(frame), .ld(ld), .ld_chb(ld_chb), .ld_frame(ld_frame)
  );

  spdif_sample_slot #(.AW(AUD_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .iside_rst_n(iside_rst_n),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_user(smp_user),
    .smp_cs(smp_cs), .consume(consume), .smp_ready(smp_ready),
    .hv(hv), .hd(hd), .hu(hu), .hc(hc)
  );

  assign reuse    = mono && ld_chb;
  assign take     = hv && !reuse;
  assign consume  = ld && take;
  assign cur_d    = take ? hd : (reuse ? a_d : '0);
  assign cur_u    = take ? hu : (reuse && a_u);
  assign cur_c    = take ? hc : (reuse && a_c);
  assign dp_v     = reuse ? a_v : !hv;
  assign bank_bit = ld_chb ? cs_b[ld_frame] : cs_a[ld_frame];
  assign kind     = ld_chb ? PRE_B : ((ld_frame == '0) ? PRE_BLK : PRE_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pat_q  <= '0;
      a_d    <= '0;
      a_u    <= 1'b0;
      a_c    <= 1'b0;
      a_v    <= 1'b1;
    end else if (ld) begin
      word_q <= build_word(cur_d, msb_first,
                           v_dp_sel ? dp_v  : v_man,
                           u_dp_sel ? cur_u : u_man,
                           c_dp_sel ? cur_c : bank_bit);
      pat_q  <= pre_pattern(kind);
      if (!ld_chb) begin
        a_d <= cur_d;
        a_u <= cur_u;
        a_c <= cur_c;
        a_v <= dp_v;
      end
    end
  end

  spdif_bmc_coder u_coder (
    .clk(clk), .rst_n(rst_n), .run(run), .active(active), .pos(pos),
    .word(word_q), .pat(pat_q), .line(tx_line)
  );
endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
  parameter int BLOCK = 192
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     run,
  input logic                     active,
  input logic [6:0]               pos,
  input logic [$clog2(BLOCK)-1:0] frame,
  input logic                     ld,
  input logic                     ld_chb,
  input logic                     consume,
  input logic                     mono,
  input logic                     smp_valid,
  input logic                     smp_ready,
  input logic                     tx_line
);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tx_line);

  a_r4_pre_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && active && pos[5:0] == 6'd0) |=> (tx_line != $past(tx_line)));

  a_r5_slot_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && active && pos[5:3] != 3'd0 && !pos[0]) |=> (tx_line != $past(tx_line)));

  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && active && pos == 7'h7F) |=> (pos == 7'd0));

  a_r10_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame <= ($clog2(BLOCK))'(BLOCK - 1));

  a_r11_one_deep: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  a_r12_mono_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ld_chb && mono) |-> !consume);
endmodule

bind spdif_tx spdif_tx_chk #(.BLOCK(BLOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .active(active), .pos(pos),
  .frame(frame), .ld(ld), .ld_chb(ld_chb), .consume(consume), .mono(mono),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .tx_line(tx_line)
);

// File: tb/spdif_tx_bench.sv
`timescale 1ns/1ps
module spdif_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, oside_rst_n = 0, iside_rst_n = 0, mono = 0, msb_first = 0;
  logic v_dp_sel = 0, v_man = 0, u_dp_sel = 0, u_man = 0, c_dp_sel = 0;
  logic [191:0] cs_a, cs_b;
  logic smp_valid = 0, smp_ready, smp_user = 0, smp_cs = 0, tx_line;
  logic [23:0] smp_data = '0;

  int checks = 0, errors = 0;
  int g_nsmp = 0;
  logic feed_en = 0;
  int fidx = 0;
  logic fire = 0;
  logic g_lvl = 0;

  always #10 clk = ~clk;

  spdif_tx u_spdif_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .oside_rst_n(oside_rst_n),
    .iside_rst_n(iside_rst_n), .mono(mono), .msb_first(msb_first),
    .v_dp_sel(v_dp_sel), .v_man(v_man), .u_dp_sel(u_dp_sel), .u_man(u_man),
    .c_dp_sel(c_dp_sel), .cs_a(cs_a), .cs_b(cs_b), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .smp_user(smp_user),
    .smp_cs(smp_cs), .tx_line(tx_line)
  );

  function automatic logic [23:0] sd(input int k);
    logic [7:0] b = k[7:0];
    return {b ^ 8'hC3, b, b ^ 8'h5A};
  endfunction
  function automatic logic su(input int k); return k[0]; endfunction
  function automatic logic sc(input int k); return k[1] ^ k[2]; endfunction

  always @(negedge clk) begin
    if (!feed_en) begin
      fidx = 0; fire = 0; smp_valid = 0;
    end else begin
      if (fire) fidx++;
      smp_valid = (fidx < g_nsmp);
      smp_data  = sd(fidx);
      smp_user  = su(fidx);
      smp_cs    = sc(fidx);
      fire      = smp_valid && smp_ready;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected 64 cells, index 0 is first on the line
  function automatic logic [63:0] ref_cells(input int kind, input logic [23:0] aud,
      input logic msb, input logic v, input logic u, input logic c, input logic p);
    logic [63:0] cl;
    logic [27:0] sl;
    logic [7:0] pat;
    logic lv;
    for (int i = 0; i < 24; i++) sl[i] = msb ? aud[23-i] : aud[i];
    sl[24] = v; sl[25] = u; sl[26] = c;
    sl[27] = 1'b0;
    for (int i = 0; i < 27; i++) sl[27] = sl[27] ^ sl[i];
    pat = (kind == 0) ? 8'b11101000 : (kind == 1) ? 8'b11100010 : 8'b11100100;
    for (int k = 0; k < 8; k++) cl[k] = pat[7-k] ^ p;
    lv = cl[7];
    for (int j = 0; j < 28; j++) begin
      lv = ~lv; cl[8+2*j] = lv;
      if (sl[j]) lv = ~lv;
      cl[9+2*j] = lv;
    end
    return cl;
  endfunction

  task automatic run_frames(input int nf, input string tag);
    for (int f = 0; f < nf; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        int s, fb, kind;
        logic av, dv, du, dc, v, u, c;
        logic [23:0] aud;
        logic [63:0] exp, got;
        fb   = f % 192;
        kind = (ch == 1) ? 2 : ((fb == 0) ? 0 : 1);
        s    = mono ? f : 2 * f + ch;
        av   = (s < g_nsmp);
        aud  = av ? sd(s) : 24'd0;
        dv   = !av;
        du   = av ? su(s) : 1'b0;
        dc   = av ? sc(s) : 1'b0;
        v    = v_dp_sel ? dv : v_man;
        u    = u_dp_sel ? du : u_man;
        c    = c_dp_sel ? dc : (ch == 1 ? cs_b[fb] : cs_a[fb]);
        exp  = ref_cells(kind, aud, msb_first, v, u, c, g_lvl);
        for (int k = 0; k < 64; k++) begin
          @(negedge clk);
          got[k] = tx_line;
        end
        chk(got == exp, $sformatf("%s frame %0d ch %0d", tag, f, ch), got, exp);
        g_lvl = exp[63];
      end
    end
  endtask

  // output side released before input side, then enable
  task automatic start_run();
    tx_en = 0; feed_en = 0; oside_rst_n = 0; iside_rst_n = 0;
    repeat (2) @(negedge clk);
    oside_rst_n = 1;
    @(negedge clk);
    iside_rst_n = 1;
    @(negedge clk);
    feed_en = 1;
    repeat (6) @(negedge clk);
    g_lvl = 0;
    tx_en = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_line == 1'b0, "R1 line low in reset", 64'(tx_line), 64'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(smp_ready == 1'b0, "R11 ready low with input reset held", 64'(smp_ready), 64'd0);
    oside_rst_n = 1; iside_rst_n = 1;
    @(negedge clk);
    chk(smp_ready == 1'b1, "R11 ready high when slot empty", 64'(smp_ready), 64'd1);
  endtask

  task automatic t_idle_held();
    logic seen;
    tx_en = 1; oside_rst_n = 0; iside_rst_n = 1; seen = 0;
    repeat (200) begin @(negedge clk); seen |= tx_line; end
    chk(!seen, "R1 output reset held keeps line low", 64'(seen), 64'd0);
    oside_rst_n = 1; iside_rst_n = 0; seen = 0;
    repeat (200) begin @(negedge clk); seen |= tx_line; end
    chk(!seen, "R1 input reset held keeps line low", 64'(seen), 64'd0);
    tx_en = 0;
  endtask

  task automatic t_stereo_block();
    mono = 0; msb_first = 0; v_dp_sel = 0; v_man = 0; u_dp_sel = 0; u_man = 0;
    c_dp_sel = 0; g_nsmp = 1000;
    start_run();
    run_frames(194, "R3 R4 R5 R6 R7 R10 R11 stereo block wrap");
  endtask

  task automatic t_msb();
    msb_first = 1; g_nsmp = 1000;
    start_run();
    run_frames(4, "R6 msb first");
    msb_first = 0;
  endtask

  task automatic t_mute();
    v_man = 1; u_man = 1; g_nsmp = 1000;
    start_run();
    run_frames(3, "R8 R9 manual mute and user");
    v_man = 0; u_man = 0;
  endtask

  task automatic t_datapath();
    v_dp_sel = 1; u_dp_sel = 1; c_dp_sel = 1; g_nsmp = 3;
    start_run();
    run_frames(3, "R8 R9 R10 R11 data path and underrun");
  endtask

  task automatic t_mono();
    mono = 1; v_dp_sel = 1; u_dp_sel = 1; c_dp_sel = 1; g_nsmp = 4;
    start_run();
    run_frames(5, "R12 mono repeat");
    mono = 0; v_dp_sel = 0; u_dp_sel = 0; c_dp_sel = 0;
  endtask

  task automatic t_stop_restart();
    logic seen;
    g_nsmp = 0; v_man = 0; u_man = 1;
    start_run();
    run_frames(2, "R2 before stop");
    tx_en = 0;
    @(negedge clk);
    chk(tx_line == 1'b0, "R2 line low one edge after enable cleared", 64'(tx_line), 64'd0);
    seen = 0;
    repeat (20) begin @(negedge clk); seen |= tx_line; end
    chk(!seen, "R2 line stays low while disabled", 64'(seen), 64'd0);
    g_lvl = 0;
    tx_en = 1;
    @(negedge clk);
    run_frames(1, "R2 R4 restart at frame 0");
    tx_en = 0; u_man = 0;
  endtask

  initial begin
    cs_a = {6{32'hC0DE_1235}};
    cs_b = {6{32'h0F0F_A5A6}};
    t_reset();
    t_idle_held();
    t_stereo_block();
    t_msb();
    t_mute();
    t_datapath();
    t_mono();
    t_stop_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule